// File: doc/BRIEF.md
# Sub-byte Packed SIMD ALU

This unit treats two 32-bit words as vectors of small integers and applies one element-wise function to every lane at once. A 2-bit precision code selects whether the word holds four 8-bit lanes, eight 4-bit lanes or sixteen 2-bit lanes. A 3-bit function code chooses one of these operations: wrapping add, wrapping subtract, left shift, right shift, maximum, minimum or average. A sign flag sets whether lanes are read as two's-complement or unsigned values for comparisons, right shifts and averaging.

The lane results appear combinationally on `res_o`. When `valid_i` is high, a rising clock edge copies them into `q_o`. The intended use is the pooling and activation stages of low-precision neural-network inference. A ReLU is an element-wise signed maximum against an all-zero B operand.

Top module: `subbyte_simd_alu`

## Requirements
- R1: Function code 000 adds lane by lane modulo 2^W, where W is the lane width. No carry passes into the next lane.
- R2: Function code 001 subtracts B from A lane by lane modulo 2^W. No borrow passes into the next lane.
- R3: Function code 010 shifts each A lane left. The shift amount is the matching B lane taken modulo W, which is its low log2(W) bits.
- R4: Function code 011 shifts each A lane right by the same amount as R3. The shift is arithmetic when `signed_i`=1 and logical when `signed_i`=0.
- R5: Function codes 100 and 101 return the larger and the smaller of the two lanes. The comparison is signed when `signed_i`=1 and unsigned otherwise.
- R6: Function code 110 returns floor((A+B)/2) per lane. The sum is formed with one extra bit, so it cannot overflow, and it is sign-extended when `signed_i`=1.
- R7: Precision code 00 selects 8-bit lanes, 01 selects 4-bit lanes and 10 selects 2-bit lanes. Code 11 behaves like 00.
- R8: Function code 111 drives an all-zero result.
- R9: A signed maximum against B=0 clears every negative lane and leaves every non-negative lane unchanged (ReLU).
- R10: Reset clears `q_o` and `q_valid_o`. A rising edge with `valid_i` high loads `res_o` into `q_o` and sets `q_valid_o` for one cycle. With `valid_i` low, `q_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Capture strobe for the result register |
| op_i | input | 3 | Function code |
| prec_i | input | 2 | Lane width code |
| signed_i | input | 1 | Two's-complement lane interpretation |
| a_i | input | 32 | Packed operand A |
| b_i | input | 32 | Packed operand B, also the per-lane shift amounts |
| res_o | output | 32 | Combinational packed result |
| q_o | output | 32 | Registered packed result |
| q_valid_o | output | 1 | High for one cycle after a capture |

## Verification
The bench places all-ones and minimum-value lanes next to each other. This exposes any carry, borrow or sign bit that leaks into a neighbouring lane; a leaking design corrupts the next lane up. Shift amounts larger than the lane width must wrap: a design that uses too many bits of B zeroes the lane instead. Signed and unsigned runs use identical bit patterns, so a comparator or right shift that ignores the flag returns the wrong lane. Averaging two maximal lanes catches a sum with no extra bit, which wraps to a small value. The reserved precision and function codes are also applied, along with held strobes, to catch stale or spurious register loads.

// File: rtl/subbyte_simd_alu.sv
module subbyte_simd_alu #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [1:0]      prec_i,
  input  logic            signed_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic [XLEN-1:0] q_o,
  output logic            q_valid_o
);

  logic [XLEN-1:0] lane_res [3];

  for (genvar g = 0; g < 3; g++) begin : g_width
    localparam int W  = 8 >> g;
    localparam int N  = XLEN / W;
    localparam int SW = $clog2(W);

    for (genvar l = 0; l < N; l++) begin : g_lane
      logic [W-1:0] a, b, y;
      logic [W:0]   ea, eb, sum;
      logic         gt;

      assign a   = a_i[l*W +: W];
      assign b   = b_i[l*W +: W];
      assign ea  = {signed_i & a[W-1], a};
      assign eb  = {signed_i & b[W-1], b};
      assign sum = ea + eb;
      assign gt  = $signed(ea) > $signed(eb);

      always_comb begin
        unique case (op_i)
          3'b000:  y = a + b;
          3'b001:  y = a - b;
          3'b010:  y = a << b[SW-1:0];
          3'b011:  y = W'($signed(ea) >>> b[SW-1:0]);
          3'b100:  y = gt ? a : b;
          3'b101:  y = gt ? b : a;
          3'b110:  y = W'(sum >> 1);
          default: y = '0;
        endcase
      end

      assign lane_res[g][l*W +: W] = y;
    end
  end

  always_comb begin
    unique case (prec_i)
      2'b01:   res_o = lane_res[1];
      2'b10:   res_o = lane_res[2];
      default: res_o = lane_res[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o       <= '0;
      q_valid_o <= 1'b0;
    end else begin
      q_valid_o <= valid_i;
      if (valid_i) q_o <= res_o;
    end
  end

  // R10
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (q_valid_o && q_o == $past(res_o)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!q_valid_o && $stable(q_o)));

  // R8
  reserved_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'b111) |-> (res_o == '0));

  // R1
  add_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'b000 && b_i == '0) |-> (res_o == a_i));

  // R5
  max_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'b100 && a_i == b_i) |-> (res_o == a_i));

endmodule

// File: tb/subbyte_simd_alu_tb.sv
module subbyte_simd_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  prec_i = '0;
  logic        signed_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [31:0] res_o, q_o;
  logic        q_valid_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subbyte_simd_alu dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .prec_i(prec_i),
    .signed_i(signed_i), .a_i(a_i), .b_i(b_i), .res_o(res_o), .q_o(q_o),
    .q_valid_o(q_valid_o)
  );

  function automatic logic [31:0] model(input logic [2:0] op, input logic [1:0] prec,
                                        input logic sgn, input logic [31:0] a,
                                        input logic [31:0] b);
    int w, mask;
    logic [31:0] res;
    w = (prec == 2'b01) ? 4 : (prec == 2'b10) ? 2 : 8;
    mask = (1 << w) - 1;
    res = '0;
    for (int l = 0; l < 32 / w; l++) begin
      int ua, ub, sa, sb, sh, r;
      ua = int'((a >> (l*w)) & 32'(mask));
      ub = int'((b >> (l*w)) & 32'(mask));
      sa = (sgn && ((ua >> (w-1)) & 1) == 1) ? ua - (1 << w) : ua;
      sb = (sgn && ((ub >> (w-1)) & 1) == 1) ? ub - (1 << w) : ub;
      sh = ub % w;
      case (op)
        3'd0: r = ua + ub;
        3'd1: r = ua - ub;
        3'd2: r = ua << sh;
        3'd3: r = sa >>> sh;
        3'd4: r = (sa > sb) ? sa : sb;
        3'd5: r = (sa < sb) ? sa : sb;
        3'd6: r = (sa + sb) >>> 1;
        default: r = 0;
      endcase
      res = res | (32'(r & mask) << (l*w));
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] op, input logic [1:0] prec,
                       input logic sgn, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp;
    exp = model(op, prec, sgn, a, b);
    @(negedge clk);
    op_i = op; prec_i = prec; signed_i = sgn; a_i = a; b_i = b; valid_i = 1'b1;
    #1 check(req, res_o, exp);
    @(negedge clk);
    valid_i = 1'b0;
    check({req, " reg"}, q_o, exp);
    check({req, " qvalid"}, {31'b0, q_valid_o}, 32'd1);
  endtask

  task automatic t_reset;
    check("R10 reset q", q_o, 32'h0);
    check("R10 reset qvalid", {31'b0, q_valid_o}, 32'd0);
  endtask

  task automatic t_add_sub;
    apply("R1 add 8b", 3'd0, 2'b00, 1'b0, 32'hFF01_7F80, 32'h0101_0180);
    apply("R1 add 4b", 3'd0, 2'b01, 1'b0, 32'hFFFF_FFFF, 32'h1111_1111);
    check("R1 add 4b wrap no carry", res_o, 32'h0);
    apply("R1 add 2b", 3'd0, 2'b10, 1'b1, 32'hFFFF_0000, 32'h5555_AAAA);
    apply("R2 sub 8b", 3'd1, 2'b00, 1'b0, 32'h0000_0100, 32'h0101_0001);
    apply("R2 sub 4b", 3'd1, 2'b01, 1'b0, 32'h0000_0000, 32'h1111_1111);
    check("R2 sub 4b borrow isolated", res_o, 32'hFFFF_FFFF);
    apply("R2 sub 2b", 3'd1, 2'b10, 1'b0, 32'h1B1B_0000, 32'hFFFF_5555);
  endtask

  task automatic t_shifts;
    apply("R3 shl 8b", 3'd2, 2'b00, 1'b0, 32'h81FF_0F01, 32'h0109_0F07);
    apply("R3 shl 4b", 3'd2, 2'b01, 1'b0, 32'hFFFF_FFFF, 32'h7654_3210);
    apply("R3 shl 2b", 3'd2, 2'b10, 1'b0, 32'h5555_FFFF, 32'hFFFF_5555);
    apply("R4 shr 8b signed", 3'd3, 2'b00, 1'b1, 32'h80F0_7F40, 32'h0702_0B03);
    apply("R4 shr 8b unsigned", 3'd3, 2'b00, 1'b0, 32'h80F0_7F40, 32'h0702_0B03);
    apply("R4 shr 4b signed", 3'd3, 2'b01, 1'b1, 32'h8888_7777, 32'h3210_7654);
    apply("R4 shr 2b signed", 3'd3, 2'b10, 1'b1, 32'hAAAA_5555, 32'h5555_FFFF);
  endtask

  task automatic t_maxmin;
    apply("R5 max 8b signed", 3'd4, 2'b00, 1'b1, 32'h807F_01FF, 32'h7F80_FF01);
    apply("R5 max 8b unsigned", 3'd4, 2'b00, 1'b0, 32'h807F_01FF, 32'h7F80_FF01);
    apply("R5 min 4b signed", 3'd5, 2'b01, 1'b1, 32'h8F70_1E2D, 32'h7F08_E1D2);
    apply("R5 min 4b unsigned", 3'd5, 2'b01, 1'b0, 32'h8F70_1E2D, 32'h7F08_E1D2);
    apply("R5 max 2b signed", 3'd4, 2'b10, 1'b1, 32'h1B1B_E4E4, 32'hE4E4_1B1B);
    apply("R5 min 2b unsigned", 3'd5, 2'b10, 1'b0, 32'h1B1B_E4E4, 32'hE4E4_1B1B);
  endtask

  task automatic t_avg;
    apply("R6 avg 8b unsigned", 3'd6, 2'b00, 1'b0, 32'hFF80_0103, 32'hFF7F_0000);
    check("R6 avg 8b max lanes", res_o & 32'hFF00_0000, 32'hFF00_0000);
    apply("R6 avg 8b signed", 3'd6, 2'b00, 1'b1, 32'h8080_FF01, 32'h807F_0000);
    apply("R6 avg 4b signed", 3'd6, 2'b01, 1'b1, 32'h87F1_8F07, 32'h87F0_1F77);
    apply("R6 avg 2b unsigned", 3'd6, 2'b10, 1'b0, 32'hFFFF_1B1B, 32'hFFFF_E4E4);
  endtask

  task automatic t_prec_relu_zero;
    apply("R7 prec 11 as 8b", 3'd0, 2'b11, 1'b0, 32'hFFFF_FFFF, 32'h0101_0101);
    check("R7 prec 11 value", res_o, 32'h0000_0000);
    apply("R9 relu 8b", 3'd4, 2'b00, 1'b1, 32'h80F0_7F01, 32'h0);
    check("R9 relu 8b value", q_o, 32'h0000_7F01);
    apply("R9 relu 2b", 3'd4, 2'b10, 1'b1, 32'hAAAA_5555, 32'h0);
    check("R9 relu 2b value", q_o, 32'h0000_5555);
    apply("R8 op 111", 3'd7, 2'b01, 1'b1, 32'hDEAD_BEEF, 32'h1234_5678);
    check("R8 op 111 value", q_o, 32'h0);
  endtask

  task automatic t_hold;
    logic [31:0] held;
    apply("R10 load", 3'd0, 2'b00, 1'b0, 32'h1122_3344, 32'h0101_0101);
    held = q_o;
    @(negedge clk);
    op_i = 3'd1; a_i = 32'hFFFF_FFFF; b_i = 32'h0; valid_i = 1'b0;
    @(negedge clk);
    check("R10 hold without valid", q_o, held);
    check("R10 qvalid low", {31'b0, q_valid_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add_sub();
    t_shifts();
    t_maxmin();
    t_avg();
    t_prec_relu_zero();
    t_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule